// File: doc/BRIEF.md
# ECAM Configuration Address Translator

This block sits between a configuration-access requester and the memory-mapped configuration window of a PCIe root complex. A requester gives a bus number, an 8-bit device/function number and a 12-bit register offset. The block packs these into a flat byte offset, adds it to a programmable 64-bit window base, and forwards the access downstream. It also decides whether the access may leave the block at all. An access that is turned away completes locally, so the requester always gets a response.

Four 32-bit registers hold the setup. One reports that the translator is present. A control word holds an enable flag and a 5-bit size field, and that field is also the highest bus number that can be reached. The last two registers hold the window base as a low word and a high word. An access is forwarded only when all of these hold: the translator is enabled, the bus is within range, and the root-bus or link-status rule passes. After reset the translator is disabled.

Top module: `ecam_xlate`

## Requirements
- R1: A forwarded access appears on `dn_valid` in the cycle after the request, with `dn_addr` = window base + ((bus << 20) | (devfn << 12) | offset), using the base held when the request was taken.
- R2: On the root bus (bus 0), an access with devfn other than 0 is rejected.
- R3: An access to a bus other than the root bus is rejected while `link_up` is low. The root bus does not depend on `link_up`.
- R4: An access whose bus number is greater than the control size field (bits 20:16) is rejected. A bus equal to the field value is allowed.
- R5: The enable flag is control bit 0 and resets to 0. While it is 0, every access is rejected.
- R6: A rejected read produces `rsp_valid` in the cycle after the request, with `rsp_rdata` = 0xFFFFFFFF, and no `dn_valid`.
- R7: A rejected write is acknowledged by `rsp_valid` in the cycle after the request, with `rsp_rdata` = 0, and no `dn_valid`.
- R8: For a forwarded read, the data returned on `dn_rdata` with `dn_rvalid` appears on `rsp_rdata` with `rsp_valid` one cycle later.
- R9: Register word 0 reads 0x00000001 (present). Word 1 is the control word and resets to 0x000C0000 (size 12, disabled). Words 2 and 3 are the low and high base words, reset to 0 and read back as written.
- R10: A forwarded write carries `req_wdata` on `dn_wdata` with `dn_write` high. It is acknowledged with `rsp_valid` and `rsp_rdata` = 0 in the same cycle as `dn_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| link_up | input | 1 | Link status |
| req_valid | input | 1 | Configuration request strobe |
| req_write | input | 1 | Request is a write |
| req_bus | input | 8 | Bus number |
| req_devfn | input | 8 | Device/function number |
| req_off | input | 12 | Register byte offset |
| req_wdata | input | 32 | Write data |
| dn_valid | output | 1 | Forwarded access strobe |
| dn_write | output | 1 | Forwarded access is a write |
| dn_addr | output | 64 | Translated address |
| dn_wdata | output | 32 | Forwarded write data |
| dn_rvalid | input | 1 | Downstream read data strobe |
| dn_rdata | input | 32 | Downstream read data |
| rsp_valid | output | 1 | Response to requester |
| rsp_rdata | output | 32 | Response data |

## Verification
The hardest corners to reach are the bus range edges, and they can only be reached by reprogramming the size field. The stimulus sets the link up and probes the bus equal to the field and the bus one above it. It then widens the field and shows that the same bus is now forwarded. The root-bus exemption from link status is checked by sending root-bus reads while the link is down, right next to non-root reads that must be refused. Every response is matched in order against a queue of expected items, which the bench builds from its own model of enable, size, link and base.

// File: rtl/ecam_pkg.sv
package ecam_pkg;
    localparam int unsigned REG_W     = 32;
    localparam int unsigned WIN_AW    = 64;
    localparam int unsigned SIZE_W    = 5;
    localparam int unsigned SIZE_LSB  = 16;
    localparam int unsigned EN_BIT    = 0;
    localparam logic [REG_W-1:0] CTRL_MASK =
        REG_W'(((1 << SIZE_W) - 1) << SIZE_LSB) | REG_W'(1 << EN_BIT);

    typedef enum logic [1:0] {
        SEL_CAP  = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_BLO  = 2'd2,
        SEL_BHI  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              en;
        logic [SIZE_W-1:0] last_bus;
        logic [WIN_AW-1:0] base;
    } win_cfg_t;
endpackage

// File: rtl/ecam_regs.sv
module ecam_regs
    import ecam_pkg::*;
#(
    parameter int unsigned SIZE_RESET = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output win_cfg_t         cfg
);
    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] blo;
        logic [REG_W-1:0] bhi;
    } regs_t;

    localparam logic [REG_W-1:0] CTRL_RST = REG_W'(SIZE_RESET << SIZE_LSB);

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (reg_sel_e'(addr))
                SEL_CTRL: regs_d.ctrl = wdata & CTRL_MASK;
                SEL_BLO:  regs_d.blo  = wdata;
                SEL_BHI:  regs_d.bhi  = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{ctrl: CTRL_RST, blo: '0, bhi: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (reg_sel_e'(addr))
            SEL_CAP:  rdata = REG_W'(1);
            SEL_CTRL: rdata = regs_q.ctrl;
            SEL_BLO:  rdata = regs_q.blo;
            default:  rdata = regs_q.bhi;
        endcase
    end

    assign cfg.en       = regs_q.ctrl[EN_BIT];
    assign cfg.last_bus = regs_q.ctrl[SIZE_LSB +: SIZE_W];
    assign cfg.base     = {regs_q.bhi, regs_q.blo};

    // R5
    ctrl_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel_e'(addr) == SEL_CTRL && !wdata[EN_BIT]) |=> !cfg.en);
endmodule

// File: rtl/ecam_gate.sv
module ecam_gate
    import ecam_pkg::*;
#(
    parameter int unsigned BUS_W    = 8,
    parameter int unsigned DEVFN_W  = 8,
    parameter int unsigned ROOT_BUS = 0
) (
    input  logic               en,
    input  logic [SIZE_W-1:0]  last_bus,
    input  logic               link_up,
    input  logic [BUS_W-1:0]   bus,
    input  logic [DEVFN_W-1:0] devfn,
    output logic               allow
);
    localparam logic [BUS_W-1:0] ROOT = BUS_W'(ROOT_BUS);

    logic in_range;
    logic path_ok;

    always_comb begin
        in_range = (bus <= BUS_W'(last_bus));
        if (bus == ROOT) begin
            path_ok = (devfn == '0);
        end else begin
            path_ok = link_up;
        end
        allow = en && in_range && path_ok;
    end
endmodule

// File: rtl/ecam_xlate.sv
module ecam_xlate
    import ecam_pkg::*;
#(
    parameter int unsigned BUS_W      = 8,
    parameter int unsigned DEVFN_W    = 8,
    parameter int unsigned OFF_W      = 12,
    parameter int unsigned ROOT_BUS   = 0,
    parameter int unsigned SIZE_RESET = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               link_up,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [BUS_W-1:0]   req_bus,
    input  logic [DEVFN_W-1:0] req_devfn,
    input  logic [OFF_W-1:0]   req_off,
    input  logic [REG_W-1:0]   req_wdata,
    output logic               dn_valid,
    output logic               dn_write,
    output logic [WIN_AW-1:0]  dn_addr,
    output logic [REG_W-1:0]   dn_wdata,
    input  logic               dn_rvalid,
    input  logic [REG_W-1:0]   dn_rdata,
    output logic               rsp_valid,
    output logic [REG_W-1:0]   rsp_rdata
);
    localparam int unsigned REL_W = BUS_W + DEVFN_W + OFF_W;

    typedef struct packed {
        logic              dn_valid;
        logic              dn_write;
        logic [WIN_AW-1:0] dn_addr;
        logic [REG_W-1:0]  dn_wdata;
        logic              rsp_valid;
        logic [REG_W-1:0]  rsp_rdata;
    } out_t;

    win_cfg_t         cfg;
    logic             allow;
    logic [REL_W-1:0] rel;
    out_t             st_d, st_q;

    ecam_regs #(.SIZE_RESET(SIZE_RESET)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    ecam_gate #(.BUS_W(BUS_W), .DEVFN_W(DEVFN_W), .ROOT_BUS(ROOT_BUS)) u_gate (
        .en       (cfg.en),
        .last_bus (cfg.last_bus),
        .link_up  (link_up),
        .bus      (req_bus),
        .devfn    (req_devfn),
        .allow    (allow)
    );

    always_comb begin
        rel = (REL_W'(req_bus) << (DEVFN_W + OFF_W))
            | (REL_W'(req_devfn) << OFF_W)
            | REL_W'(req_off);
        st_d           = st_q;
        st_d.dn_valid  = 1'b0;
        st_d.rsp_valid = 1'b0;
        if (req_valid) begin
            if (allow) begin
                st_d.dn_valid = 1'b1;
                st_d.dn_write = req_write;
                st_d.dn_addr  = cfg.base + WIN_AW'(rel);
                st_d.dn_wdata = req_write ? req_wdata : '0;
                if (req_write) begin
                    st_d.rsp_valid = 1'b1;
                    st_d.rsp_rdata = '0;
                end
            end else begin
                st_d.rsp_valid = 1'b1;
                st_d.rsp_rdata = req_write ? '0 : '1;
            end
        end
        if (dn_rvalid) begin
            st_d.rsp_valid = 1'b1;
            st_d.rsp_rdata = dn_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dn_valid  = st_q.dn_valid;
    assign dn_write  = st_q.dn_write;
    assign dn_addr   = st_q.dn_addr;
    assign dn_wdata  = st_q.dn_wdata;
    assign rsp_valid = st_q.rsp_valid;
    assign rsp_rdata = st_q.rsp_rdata;

    // R1
    addr_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && allow) |=> (dn_valid &&
            (dn_addr - $past(cfg.base)) ==
            WIN_AW'({$past(req_bus), $past(req_devfn), $past(req_off)})));
    // R2
    root_devfn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_bus == BUS_W'(ROOT_BUS) && req_devfn != '0) |=> !dn_valid);
    // R3
    link_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_bus != BUS_W'(ROOT_BUS) && !link_up) |=> !dn_valid);
    // R4
    bus_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_bus > BUS_W'(cfg.last_bus)) |=> !dn_valid);
    // R5
    disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg.en) |=> (!dn_valid && rsp_valid));
    // R6
    reject_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !allow && !dn_rvalid) |=> (rsp_valid && rsp_rdata == '1));
    // R10
    write_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_write) |-> (rsp_valid && rsp_rdata == '0));
endmodule

// File: tb/test_ecam_xlate.sv
module test_ecam_xlate;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        bit          is_dn;
        bit          wr;
        logic [63:0] addr;
        logic [31:0] data;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        link_up = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [7:0]  req_devfn = '0;
    logic [11:0] req_off = '0;
    logic [31:0] req_wdata = '0;
    logic        dn_valid, dn_write;
    logic [63:0] dn_addr;
    logic [31:0] dn_wdata;
    logic        dn_rvalid = 1'b0;
    logic [31:0] dn_rdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int total = 0;
    int bad = 0;
    bit done = 0;
    exp_t q[$];

    bit          m_en = 0;
    int          m_size = 12;
    logic [63:0] m_base = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecam_xlate i_ecam_xlate (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_up(link_up),
        .req_valid(req_valid), .req_write(req_write), .req_bus(req_bus),
        .req_devfn(req_devfn), .req_off(req_off), .req_wdata(req_wdata),
        .dn_valid(dn_valid), .dn_write(dn_write), .dn_addr(dn_addr),
        .dn_wdata(dn_wdata), .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pop_check(bit is_dn, bit wr, logic [63:0] addr, logic [31:0] data);
        exp_t e;
        total++;
        if (q.size() == 0) begin
            bad++;
            $display("FAIL unexpected %s output: actual=%h expected=none",
                     is_dn ? "downstream" : "response", is_dn ? addr : 64'(data));
            return;
        end
        e = q.pop_front();
        if (e.is_dn != is_dn) begin
            bad++;
            $display("FAIL %s: actual kind=%0d expected kind=%0d", e.tag, is_dn, e.is_dn);
        end else if (is_dn && (e.wr != wr || e.addr !== addr || (wr && e.data !== data))) begin
            bad++;
            $display("FAIL %s: actual wr=%0d addr=%h data=%h expected wr=%0d addr=%h data=%h",
                     e.tag, wr, addr, data, e.wr, e.addr, e.data);
        end else if (!is_dn && e.data !== data) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", e.tag, data, e.data);
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (dn_valid)  pop_check(1'b1, dn_write, dn_addr, dn_wdata);
                if (rsp_valid) pop_check(1'b0, 1'b0, 64'd0, rsp_rdata);
            end
        end
    end

    task automatic reg_write(logic [1:0] a, logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        if (a == 2'd1) begin
            m_en = d[0];
            m_size = int'(d[20:16]);
        end
        if (a == 2'd2) m_base[31:0] = d;
        if (a == 2'd3) m_base[63:32] = d;
    endtask

    task automatic reg_check(string tag, logic [1:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        check(tag, 64'(reg_rdata), 64'(exp));
    endtask

    // request with expected outcome computed from the model
    task automatic access(string tag, bit wr, int bus, int devfn, int off, logic [31:0] d);
        exp_t e;
        bit ok;
        ok = m_en && (bus <= m_size) && ((bus == 0) ? (devfn == 0) : link_up);
        e.tag = tag;
        if (ok) begin
            e.is_dn = 1; e.wr = wr; e.data = d;
            e.addr = m_base + ((64'(bus) << 20) | (64'(devfn) << 12) | 64'(off));
            q.push_back(e);
            if (wr) begin
                e.is_dn = 0; e.data = '0; q.push_back(e);
            end
        end else begin
            e.is_dn = 0; e.wr = 0; e.addr = '0;
            e.data = wr ? 32'h0 : 32'hFFFF_FFFF;
            q.push_back(e);
        end
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_bus = 8'(bus);
        req_devfn = 8'(devfn); req_off = 12'(off); req_wdata = d;
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic read_return(string tag, logic [31:0] d);
        exp_t e;
        e.is_dn = 0; e.wr = 0; e.addr = '0; e.data = d; e.tag = tag;
        q.push_back(e);
        @(posedge clk); #1;
        dn_rvalid = 1'b1; dn_rdata = d;
        @(posedge clk); #1;
        dn_rvalid = 1'b0;
        @(posedge clk); #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        check("R6 reset dn_valid", 64'(dn_valid), 64'd0);
        check("R6 reset rsp_valid", 64'(rsp_valid), 64'd0);
        reg_check("R9 capability", 2'd0, 32'h0000_0001);
        reg_check("R9 control reset", 2'd1, 32'h000C_0000);
        reg_check("R9 base lo reset", 2'd2, 32'h0);

        access("R5 disabled read rejected", 0, 0, 0, 8'h10, 0);
        access("R5 disabled write dropped", 1, 0, 0, 8'h10, 32'h1234);

        reg_write(2'd2, 32'h1000_0000);
        reg_write(2'd3, 32'h0000_0002);
        reg_check("R9 base lo", 2'd2, 32'h1000_0000);
        reg_check("R9 base hi", 2'd3, 32'h0000_0002);
        reg_write(2'd1, 32'h000C_0001);
        reg_check("R9 control enabled", 2'd1, 32'h000C_0001);

        access("R1 R3 root read with link down", 0, 0, 0, 12'h010, 0);
        read_return("R8 read data returned", 32'hCAFE_F00D);
        access("R2 root devfn nonzero", 0, 0, 8, 12'h000, 0);
        access("R3 R6 nonroot link down read", 0, 1, 8'h0A, 12'h044, 0);
        access("R3 R7 nonroot link down write", 1, 1, 8'h0A, 12'h044, 32'hDEAD_BEEF);

        link_up = 1'b1;
        access("R10 R1 forwarded write", 1, 3, 8'h1F, 12'hFFC, 32'hA5A5_0F0F);
        access("R1 forwarded read high devfn", 0, 2, 8'hFF, 12'h100, 0);
        read_return("R8 second read data", 32'h0000_0001);
        access("R4 bus equal to size", 0, 12, 0, 12'h004, 0);
        read_return("R8 read at last bus", 32'h1111_2222);
        access("R4 bus above size", 0, 13, 0, 12'h004, 0);
        reg_write(2'd1, 32'h0014_0001);
        access("R4 bus within widened size", 0, 13, 0, 12'h004, 0);
        read_return("R8 read after resize", 32'h3333_4444);
        access("R4 bus above widened size", 1, 21, 0, 12'h0, 32'h5);

        reg_write(2'd1, 32'h0014_0000);
        access("R5 disabled again read", 0, 0, 0, 12'h0, 0);
        access("R5 disabled again write", 1, 2, 1, 12'h8, 32'h77);

        repeat (4) @(posedge clk);
        check("R1 all expected outputs seen", 64'(q.size()), 64'd0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule